// File: doc/BRIEF.md
# Four-Channel Buffered PWM Controller

This block produces four independent pulse-width-modulated outputs and is programmed over a plain 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. A write commits on the rising clock edge at which `bus_we` is high. Reads need no strobe: `bus_rdata` follows `bus_addr` within the same cycle. There is no back-pressure. Every access completes at once.

Each channel has a prescaler, a 16-bit counter and a compare. The prescaler divides the clock by a power of two. The output is active while the count is below the duty value, and a per-channel polarity bit can invert it.

The duty and period of a running channel are changed through update registers. Their contents are copied into the active values only when the counter wraps, so a period is never cut short or torn. Channels are started and stopped through separate set and clear registers, and a status register shows which channels run.

Top module: `quad_pwm`

## Requirements
- R1: Writing address 0x004 starts every channel n whose write-data bit n is 1. Bits written as 0 leave their channels unchanged. Status (address 0x00C, bits 3:0, bit n = channel n) shows the running set from the cycle after the write.
- R2: Writing address 0x008 stops every channel n whose write-data bit n is 1. Other channels are unaffected.
- R3: Reads of 0x000, 0x004 and 0x008, and of any unmapped address, return 0. After reset the status reads 0.
- R4: Channel c's registers sit at 0x200 + c*0x20 plus the following offsets:
  - 0x00: mode, with the prescale exponent in bits 4:0 and polarity in bit 9.
  - 0x04: duty.
  - 0x08: duty update.
  - 0x0C: period.
  - 0x10: period update.
  
  Each register reads back its stored value. After reset the period and period update are 1, and every other field is 0.
- R5: A period or period-update write of 0 is stored as 1.
- R6: A running channel counts 0 up to period-1, advancing once per prescaled tick. With polarity 0 the output is 1 while count < duty, and 0 otherwise.
- R7: Mode bit 9 set inverts the output. A stopped channel drives the value of bit 9.
- R8: A tick occurs every 2^p clocks, where p is mode bits 4:0. Any p above 16 acts as 16, while the register still reads back the value written.
- R9: Update registers may be written at any time and read back their own value. At each counter wrap, the active duty and period take the update values held before that edge.
- R10: A direct duty or period write to a stopped channel loads both the active and the update register. The same write to a running channel is ignored.
- R11: A duty of 0 gives a constant inactive output. A duty at or above the period gives a constant active output.
- R12: A stopped channel holds its counter and prescaler at 0. Starting it begins a fresh period at count 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, committed on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 4 | Channel outputs, bit n = channel n |

## Verification
Internal state is visible almost immediately. A wrong counter or prescaler value shows up on `pwm_out` as a shifted or stretched edge, within one period of that channel. A late or early update load moves the next edge and changes the active duty read back at offset 0x04. A lost enable bit shows up both in the status read and on the pin in the next cycle. The bench therefore compares all four pins against a behavioural model on every clock. It reads back registers after each group of writes.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned CH_OFF_W = 5;

  localparam logic [ADDR_W-1:0] G_MODE = 12'h000;
  localparam logic [ADDR_W-1:0] G_ENA  = 12'h004;
  localparam logic [ADDR_W-1:0] G_DIS  = 12'h008;
  localparam logic [ADDR_W-1:0] G_STAT = 12'h00C;

  // channel windows: base aligned to stride, stride = 2**CH_OFF_W
  localparam int unsigned CH_BASE   = 32'h200;
  localparam int unsigned CH_STRIDE = 32'd1 << CH_OFF_W;

  localparam logic [CH_OFF_W-1:0] O_MODE     = 5'h00;
  localparam logic [CH_OFF_W-1:0] O_DUTY     = 5'h04;
  localparam logic [CH_OFF_W-1:0] O_DUTY_UPD = 5'h08;
  localparam logic [CH_OFF_W-1:0] O_PER      = 5'h0C;
  localparam logic [CH_OFF_W-1:0] O_PER_UPD  = 5'h10;

  localparam int unsigned POL_BIT = 9;

  typedef enum logic [2:0] {
    CR_NONE,
    CR_MODE,
    CR_DUTY,
    CR_DUTY_UPD,
    CR_PER,
    CR_PER_UPD
  } chan_reg_e;

  function automatic chan_reg_e decode_chan(input logic [CH_OFF_W-1:0] off);
    case (off)
      O_MODE:     return CR_MODE;
      O_DUTY:     return CR_DUTY;
      O_DUTY_UPD: return CR_DUTY_UPD;
      O_PER:      return CR_PER;
      O_PER_UPD:  return CR_PER_UPD;
      default:    return CR_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int unsigned MAX_EXP = 16,
  parameter int unsigned EXP_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int unsigned PC_W = (MAX_EXP > 0) ? MAX_EXP : 1;

  logic [PC_W-1:0]  pc_q;
  logic [PC_W-1:0]  mask;
  logic [EXP_W-1:0] eff;

  always_comb begin
    eff = (exp_i > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : exp_i;
    for (int b = 0; b < int'(PC_W); b++) begin
      mask[b] = (EXP_W'(b) < eff);
    end
  end

  assign tick_o = run_i && ((pc_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= '0;
    else if (!run_i) pc_q <= '0;
    else             pc_q <= pc_q + PC_W'(1);
  end

  // R8: with a nonzero exponent two ticks never fall on consecutive clocks
  a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && tick_o && eff != '0 && $stable(exp_i)) |-> !$past(tick_o));

  // R12: a stopped channel's divider restarts from zero
  a_r12_idle_divider: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (pc_q == '0));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned EXP_W   = 5,
  parameter int unsigned MAX_EXP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             wr_i,
  input  chan_reg_e        sel_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             pwm_o
);
  logic [EXP_W-1:0] exp_q;
  logic             pol_q;
  logic [CNT_W-1:0] duty_q, duty_upd_q, per_q, per_upd_q, cnt_q;
  logic [CNT_W-1:0] per_val;
  logic             tick, wrap;
  logic             wr_mode, wr_duty_dir, wr_per_dir, wr_duty_upd, wr_per_upd;

  assign per_val     = (wdata_i == '0) ? CNT_W'(1) : wdata_i;
  assign wr_mode     = wr_i && (sel_i == CR_MODE);
  assign wr_duty_dir = wr_i && (sel_i == CR_DUTY) && !run_i;
  assign wr_per_dir  = wr_i && (sel_i == CR_PER) && !run_i;
  assign wr_duty_upd = wr_duty_dir || (wr_i && (sel_i == CR_DUTY_UPD));
  assign wr_per_upd  = wr_per_dir  || (wr_i && (sel_i == CR_PER_UPD));

  pwm_prescale #(
    .MAX_EXP (MAX_EXP),
    .EXP_W   (EXP_W)
  ) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_i),
    .exp_i  (exp_q),
    .tick_o (tick)
  );

  assign wrap = tick && (cnt_q >= per_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= '0;
      pol_q <= 1'b0;
    end else if (wr_mode) begin
      exp_q <= wdata_i[EXP_W-1:0];
      pol_q <= wdata_i[POL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           duty_q <= '0;
    else if (wr_duty_dir) duty_q <= wdata_i;
    else if (wrap)        duty_q <= duty_upd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          per_q <= CNT_W'(1);
    else if (wr_per_dir) per_q <= per_val;
    else if (wrap)       per_q <= per_upd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           duty_upd_q <= '0;
    else if (wr_duty_upd) duty_upd_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          per_upd_q <= CNT_W'(1);
    else if (wr_per_upd) per_upd_q <= per_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (wrap)   cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + CNT_W'(1);
  end

  assign pwm_o = pol_q ^ (run_i && (cnt_q < duty_q));

  always_comb begin
    rdata_o = '0;
    case (sel_i)
      CR_MODE: begin
        rdata_o[POL_BIT]   = pol_q;
        rdata_o[EXP_W-1:0] = exp_q;
      end
      CR_DUTY:     rdata_o = REG_W'(duty_q);
      CR_DUTY_UPD: rdata_o = REG_W'(duty_upd_q);
      CR_PER:      rdata_o = REG_W'(per_q);
      CR_PER_UPD:  rdata_o = REG_W'(per_upd_q);
      default:     rdata_o = '0;
    endcase
  end

  // R5: neither period register ever holds zero
  a_r5_period_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q != '0) && (per_upd_q != '0));

  // R6: a running counter stays inside the active period
  a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < per_q));

  // R12: stopping clears the counter
  a_r12_idle_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));

  // R7: a stopped channel drives its polarity level
  a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> (pwm_o == pol_q));

  // R9: while running, the active period only changes at a wrap
  a_r9_load_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && per_q != $past(per_q))
      |-> ($past(cnt_q) == $past(per_q) - CNT_W'(1)));
endmodule

// File: rtl/quad_pwm.sv
module quad_pwm
  import pwm_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned EXP_W   = 5,
  parameter int unsigned MAX_EXP = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0] run_q;
  logic [REG_W-1:0]  ch_rdata [NUM_CH];
  logic              wr_ena, wr_dis;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[REG_W-1:CNT_W];
  assign wr_ena = bus_we && (bus_addr == G_ENA);
  assign wr_dis = bus_we && (bus_addr == G_DIS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (wr_ena) run_q <= run_q | bus_wdata[NUM_CH-1:0];
    else if (wr_dis) run_q <= run_q & ~bus_wdata[NUM_CH-1:0];
  end

  for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_ch
    localparam int unsigned LO = CH_BASE + i * CH_STRIDE;
    logic      hit;
    chan_reg_e sel;

    assign hit = (32'(bus_addr) >= LO) && (32'(bus_addr) < LO + CH_STRIDE);
    assign sel = hit ? decode_chan(bus_addr[CH_OFF_W-1:0]) : CR_NONE;

    pwm_channel #(
      .CNT_W   (CNT_W),
      .EXP_W   (EXP_W),
      .MAX_EXP (MAX_EXP)
    ) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (run_q[i]),
      .wr_i    (bus_we && hit),
      .sel_i   (sel),
      .wdata_i (bus_wdata[CNT_W-1:0]),
      .rdata_o (ch_rdata[i]),
      .pwm_o   (pwm_out[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == G_STAT) begin
      bus_rdata = REG_W'(run_q);
    end else begin
      for (int i = 0; i < int'(NUM_CH); i++) bus_rdata = bus_rdata | ch_rdata[i];
    end
  end

  // R1: every bit written as 1 to the enable register is running next cycle
  a_r1_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ena |=> ((run_q & $past(bus_wdata[NUM_CH-1:0])) == $past(bus_wdata[NUM_CH-1:0])));

  // R1: bits written as 0 keep their previous state
  a_r1_zero_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ena |=> ((run_q & ~$past(bus_wdata[NUM_CH-1:0]))
                == ($past(run_q) & ~$past(bus_wdata[NUM_CH-1:0]))));

  // R2: every bit written as 1 to the disable register is stopped next cycle
  a_r2_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis |=> ((run_q & $past(bus_wdata[NUM_CH-1:0])) == '0));

  // R2: without a bus write the running set holds
  a_r2_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(run_q));
endmodule

// File: tb/quad_pwm_tb.sv
`timescale 1ns/1ps
module quad_pwm_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;
  string cur_req = "R6";

  // behavioural model state
  int       m_per [4], m_pupd [4], m_duty [4], m_dupd [4];
  int       m_exp [4], m_pol [4], m_cnt [4], m_pc [4];
  bit [3:0] m_run;

  quad_pwm u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  always #10 clk = ~clk;

  localparam int CH0 = 'h200, CH1 = 'h220, CH2 = 'h240, CH3 = 'h260;

  function automatic int eff_exp(input int e);
    return (e > 16) ? 16 : e;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_per[c] = 1; m_pupd[c] = 1; m_duty[c] = 0; m_dupd[c] = 0;
        m_exp[c] = 0; m_pol[c] = 0; m_cnt[c] = 0; m_pc[c] = 0;
      end
      m_run = '0;
    end else begin
      bit [3:0] nr;
      nr = m_run;
      if (bus_we && bus_addr == 12'h004) nr = nr | bus_wdata[3:0];
      if (bus_we && bus_addr == 12'h008) nr = nr & ~bus_wdata[3:0];
      for (int c = 0; c < 4; c++) begin
        int od, op, w, wp, rel;
        bit tk;
        od = m_dupd[c];
        op = m_pupd[c];
        if (m_run[c]) begin
          tk = ((m_pc[c] + 1) % (1 << eff_exp(m_exp[c]))) == 0;
          m_pc[c] = m_pc[c] + 1;
          if (tk) begin
            if (m_cnt[c] == m_per[c] - 1) begin
              m_cnt[c] = 0; m_per[c] = op; m_duty[c] = od;
            end else m_cnt[c] = m_cnt[c] + 1;
          end
        end else begin
          m_pc[c] = 0; m_cnt[c] = 0;
        end
        if (bus_we) begin
          w   = int'(bus_wdata[15:0]);
          wp  = (w == 0) ? 1 : w;
          rel = int'(bus_addr) - ('h200 + c * 'h20);
          case (rel)
            0:  begin m_exp[c] = int'(bus_wdata[4:0]); m_pol[c] = int'(bus_wdata[9]); end
            4:  if (!m_run[c]) begin m_duty[c] = w; m_dupd[c] = w; end
            8:  m_dupd[c] = w;
            12: if (!m_run[c]) begin m_per[c] = wp; m_pupd[c] = wp; end
            16: m_pupd[c] = wp;
            default: ;
          endcase
        end
      end
      m_run = nr;
    end
  end

  function automatic int exp_rd(input int a);
    int c, off;
    if (a == 'h00C) return int'(m_run);
    if (a < 'h200) return 0;
    c   = (a - 'h200) / 32;
    off = (a - 'h200) % 32;
    if (c > 3) return 0;
    case (off)
      0:  return m_exp[c] | (m_pol[c] << 9);
      4:  return m_duty[c];
      8:  return m_dupd[c];
      12: return m_per[c];
      16: return m_pupd[c];
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = 12'(a); bus_wdata = 32'(d); bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_model(input int a, input string req);
    @(negedge clk);
    bus_addr = 12'(a);
    #1 chk(req, bus_rdata, 32'(exp_rd(a)));
  endtask

  task automatic rd_exp(input int a, input int e, input string req);
    @(negedge clk);
    bus_addr = 12'(a);
    #1 chk(req, bus_rdata, 32'(e));
  endtask

  task automatic pin_exp(input int ch, input bit e, input string req);
    #2 chk(req, 32'(pwm_out[ch]), 32'(e));
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // per-cycle comparison of all four pins against the model (R6, R7, R11 ...)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      logic [3:0] e;
      for (int c = 0; c < 4; c++)
        e[c] = m_pol[c][0] ^ (m_run[c] && (m_cnt[c] < m_duty[c]));
      chk(cur_req, 32'(pwm_out), 32'(e));
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd_exp('h00C, 0, "R3");
    rd_exp(CH0 + 'hC, 1, "R4");
    rd_exp(CH0 + 'h10, 1, "R4");
    pin_exp(0, 1'b0, "R7");

    // program stopped channels directly (R10, R4)
    cur_req = "R10";
    wr(CH0 + 'hC, 10); wr(CH0 + 'h4, 3);
    rd_exp(CH0 + 'h4, 3, "R10");
    rd_exp(CH0 + 'h8, 3, "R10");
    wr(CH1 + 'hC, 8); wr(CH1 + 'h4, 8);
    wr(CH2 + 'hC, 5); wr(CH2 + 'h0, 1 << 9);
    rd_exp(CH2 + 'h0, 'h200, "R7");
    wr(CH3 + 'hC, 4); wr(CH3 + 'h4, 2); wr(CH3 + 'h0, 2);
    rd_exp(CH3 + 'h0, 2, "R4");
    rd_exp('h27C, 0, "R3");

    // enable in two steps, zero bits must not disturb (R1)
    cur_req = "R1";
    wr('h004, 'h5);
    rd_exp('h00C, 'h5, "R1");
    wr('h004, 'hA);
    rd_exp('h00C, 'hF, "R1");
    rd_exp('h000, 0, "R3");
    rd_exp('h004, 0, "R3");
    rd_exp('h008, 0, "R3");

    cur_req = "R6";
    repeat (60) @(negedge clk);
    pin_exp(1, 1'b1, "R11");
    pin_exp(2, 1'b1, "R11");

    // direct write while running is ignored (R10)
    cur_req = "R10";
    wr(CH0 + 'h4, 7);
    rd_exp(CH0 + 'h4, 3, "R10");

    // buffered update applied at wrap (R9)
    cur_req = "R9";
    wr(CH0 + 'h8, 6); wr(CH0 + 'h10, 12);
    rd_exp(CH0 + 'h8, 6, "R9");
    rd_model(CH0 + 'h4, "R9");
    repeat (40) @(negedge clk);
    rd_exp(CH0 + 'h4, 6, "R9");
    rd_exp(CH0 + 'hC, 12, "R9");

    // zero period stored as one (R5)
    cur_req = "R5";
    wr(CH1 + 'h10, 0);
    rd_exp(CH1 + 'h10, 1, "R5");
    repeat (20) @(negedge clk);
    pin_exp(1, 1'b1, "R11");

    // stop channel 0 (R2, R7)
    cur_req = "R2";
    wr('h008, 'h1);
    rd_exp('h00C, 'hE, "R2");
    repeat (3) @(negedge clk);
    pin_exp(0, 1'b0, "R7");
    wr(CH0 + 'hC, 0);
    rd_exp(CH0 + 'hC, 1, "R5");

    // restart begins at count 0 (R12)
    cur_req = "R12";
    wr(CH0 + 'hC, 10); wr(CH0 + 'h4, 3);
    wr('h004, 'h1);
    pin_exp(0, 1'b1, "R12");
    @(negedge clk); @(negedge clk);
    pin_exp(0, 1'b1, "R12");
    @(negedge clk);
    pin_exp(0, 1'b0, "R12");

    // exponent above 16 acts as 16 (R8)
    cur_req = "R8";
    wr('h008, 'h8);
    wr(CH3 + 'hC, 2); wr(CH3 + 'h4, 1); wr(CH3 + 'h0, 'h11);
    rd_exp(CH3 + 'h0, 'h11, "R8");
    wr('h004, 'h8);
    repeat (65530) @(negedge clk);
    pin_exp(3, 1'b1, "R8");
    repeat (10) @(negedge clk);
    pin_exp(3, 1'b0, "R8");

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule